// File: doc/BRIEF.md
# Register-Bank Bus Slave

This block is a memory-mapped slave for a 32-bit pipelined AHB-Lite style bus. It holds a small bank of read/write registers. Each access is split in two: the slave samples address and control on the rising clock edge that ends the address phase. It then performs the register access in the data phase that follows. Because the controls are held in a register, a new address phase can overlap the data phase of the previous transfer, so back-to-back accesses run with no wait states.

Only real transfer types (new or sequential) cause an access. Idle and busy slots, cycles where the slave is not selected, and cycles where the bus is stalled are ignored. Narrow writes touch only the byte lanes chosen by the size and the low address bits. A transfer wider than the data bus is refused with a two-cycle error response. A burst is simply a run of single transfers.

Top module: `regbank_slave`

## Requirements
- R1: After reset every register reads as zero, `hready_out` is 1, `hresp` is 0 (OKAY) and `hrdata` is zero.
- R2: A word write (`hsize`=2) to the register selected by `haddr[4:2]` stores `hwdata` from the following cycle; a later read of that register returns it on `hrdata` during the read's data phase.
- R3: A byte write (`hsize`=0) updates only lane `haddr[1:0]`, where lane k is bits 8k+7..8k; the other lanes keep their value.
- R4: A halfword write (`hsize`=1) updates lanes 0 and 1 when `haddr[1]` is 0 and lanes 2 and 3 when it is 1; `haddr[0]` is not used.
- R5: An address phase is captured only when `hsel`=1, `hready_in`=1 and `htrans` is 2'b10 (new) or 2'b11 (sequential); otherwise (`htrans` 2'b00 idle or 2'b01 busy) no register changes and the next cycle gives `hrdata`=0 with an OKAY zero-wait response.
- R6: A write followed at once by a read of the same register in the next address phase returns the newly written value.
- R7: A captured transfer with `hsize` greater than 2 gets ERROR (`hresp`=1) for two cycles, with `hready_out` 0 in the first and 1 in the second, and changes no register.
- R8: Every supported transfer, and every cycle with no transfer, completes with `hready_out`=1 and `hresp`=0.
- R9: `hrdata` is zero in any cycle that is not the data phase of a supported read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Bus clock, rising edge |
| hresetn | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave select from the address decoder |
| haddr | input | 32 | Byte address of the address phase |
| hwrite | input | 1 | 1 = write, 0 = read |
| htrans | input | 2 | Transfer type: 00 idle, 01 busy, 10 new, 11 sequential |
| hsize | input | 3 | Transfer size, 2^hsize bytes |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready_in | input | 1 | Bus-wide ready; 1 lets the address phase complete |
| hrdata | output | 32 | Read data of the current data phase |
| hready_out | output | 1 | 1 = this slave's data phase is complete |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |

## Verification
The bench builds the block with its defaults: a 32-bit data bus, a 32-bit address and eight registers. With these values the random stream can hit every register index and every byte-lane pattern. Sizes from 3 to 7 are all oversize against 32 bits, so the error path is exercised with every illegal size. The bench loops `hready_out` back into `hready_in`, so the stall in the first error cycle blocks the next address phase just as on a real bus. A separate gate forces `hready_in` low to show that a stalled address phase is not captured.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    typedef logic [1:0] xfer_kind_t;

    localparam xfer_kind_t KIND_IDLE   = 2'b00;
    localparam xfer_kind_t KIND_BUSY   = 2'b01;
    localparam xfer_kind_t KIND_NEW    = 2'b10;
    localparam xfer_kind_t KIND_FOLLOW = 2'b11;

    // a type with the upper bit set asks for a real access
    function automatic logic kind_is_access(xfer_kind_t k);
        return k[1];
    endfunction

endpackage

// File: rtl/regbank_lanes.sv
module regbank_lanes #(
    parameter int BYTES = 4,
    parameter int OFF_W = 2
) (
    input  logic [2:0]       hsize,
    input  logic [OFF_W-1:0] addr_lo,
    output logic [BYTES-1:0] lanes,
    output logic             too_wide
);

    assign too_wide = (hsize > 3'(OFF_W));

    // a lane is hit when it sits in the same size-aligned group as the address
    for (genvar k = 0; k < BYTES; k++) begin : g_lane
        assign lanes[k] = !too_wide &&
                          ((OFF_W'(k) >> hsize) == (addr_lo >> hsize));
    end

endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl #(
    parameter int BYTES = 4,
    parameter int IDX_W = 3
) (
    input  logic             hclk,
    input  logic             hresetn,
    input  logic             capture,
    input  logic             hready_in,
    input  logic             cap_write,
    input  logic             cap_err,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [BYTES-1:0] cap_lanes,
    output logic             wr_en,
    output logic             rd_en,
    output logic [IDX_W-1:0] dp_idx,
    output logic [BYTES-1:0] dp_lanes,
    output logic             hready_out,
    output logic             hresp
);

    typedef struct packed {
        logic             valid;
        logic             write;
        logic             err;
        logic             err_tail;
        logic [IDX_W-1:0] idx;
        logic [BYTES-1:0] lanes;
    } dphase_t;

    dphase_t st_d, st_q;
    logic    err_head;

    assign err_head = st_q.valid && st_q.err && !st_q.err_tail;

    always_comb begin
        st_d = st_q;
        if (hready_in) begin
            st_d.valid = capture;
            st_d.write = cap_write;
            st_d.err   = cap_err;
            st_d.idx   = cap_idx;
            st_d.lanes = cap_lanes;
        end
        if (err_head) begin
            st_d.err_tail = 1'b1;
        end else if (hready_in) begin
            st_d.err_tail = 1'b0;
        end
    end

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en      = st_q.valid && st_q.write && !st_q.err;
    assign rd_en      = st_q.valid && !st_q.write && !st_q.err;
    assign dp_idx     = st_q.idx;
    assign dp_lanes   = st_q.lanes;
    assign hready_out = !err_head;
    assign hresp      = st_q.valid && st_q.err;

endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int BYTES    = DATA_W / 8,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTES-1:0]  lanes,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] bank_d [NUM_REGS];
    logic [DATA_W-1:0] bank_q [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_comb begin
            bank_d[r] = bank_q[r];
            if (wr_en && (idx == IDX_W'(r))) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (lanes[b]) begin
                        bank_d[r][8*b +: 8] = wdata[8*b +: 8];
                    end
                end
            end
        end

        always_ff @(posedge hclk or negedge hresetn) begin
            if (!hresetn) begin
                bank_q[r] <= '0;
            end else begin
                bank_q[r] <= bank_d[r];
            end
        end
    end

    assign rdata = rd_en ? bank_q[idx] : '0;

endmodule

// File: rtl/regbank_slave.sv
module regbank_slave #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    input  logic [1:0]        htrans,
    input  logic [2:0]        hsize,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready_in,
    output logic [DATA_W-1:0] hrdata,
    output logic              hready_out,
    output logic              hresp
);

    import regbank_pkg::*;

    localparam int BYTES = DATA_W / 8;
    localparam int OFF_W = $clog2(BYTES);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic             capture;
    logic             cap_err;
    logic [BYTES-1:0] cap_lanes;
    logic [IDX_W-1:0] cap_idx;
    logic             wr_en, rd_en;
    logic [IDX_W-1:0] dp_idx;
    logic [BYTES-1:0] dp_lanes;
    logic             unused_addr_hi;

    assign capture        = hsel && hready_in && kind_is_access(htrans);
    assign cap_idx        = haddr[OFF_W +: IDX_W];
    assign unused_addr_hi = ^haddr[ADDR_W-1:OFF_W+IDX_W];

    regbank_lanes #(.BYTES(BYTES), .OFF_W(OFF_W)) u_lanes (
        .hsize    (hsize),
        .addr_lo  (haddr[OFF_W-1:0]),
        .lanes    (cap_lanes),
        .too_wide (cap_err)
    );

    regbank_ctrl #(.BYTES(BYTES), .IDX_W(IDX_W)) u_ctrl (
        .hclk       (hclk),
        .hresetn    (hresetn),
        .capture    (capture),
        .hready_in  (hready_in),
        .cap_write  (hwrite),
        .cap_err    (cap_err),
        .cap_idx    (cap_idx),
        .cap_lanes  (cap_lanes),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .dp_idx     (dp_idx),
        .dp_lanes   (dp_lanes),
        .hready_out (hready_out),
        .hresp      (hresp)
    );

    regbank_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
        .hclk    (hclk),
        .hresetn (hresetn),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .idx     (dp_idx),
        .lanes   (dp_lanes),
        .wdata   (hwdata),
        .rdata   (hrdata)
    );

endmodule

// File: rtl/regbank_checker.sv
module regbank_checker #(
    parameter int DATA_W = 32
) (
    input logic              hclk,
    input logic              hresetn,
    input logic              hsel,
    input logic              hwrite,
    input logic [1:0]        htrans,
    input logic              hready_in,
    input logic [DATA_W-1:0] hrdata,
    input logic              hready_out,
    input logic              hresp
);

    logic live_q;

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
        end
    end

    // R1: leaving reset gives an OKAY, ready bus
    a_r1_reset_okay: assert property (@(posedge hclk) disable iff (!hresetn)
        $rose(hresetn) |-> (hready_out && !hresp));

    // R7: a stall is only ever the first error cycle
    a_r7_err_first: assert property (@(posedge hclk) disable iff (!hresetn)
        !hready_out |-> hresp);

    // R7: the error always finishes in a second, ready cycle
    a_r7_err_second: assert property (@(posedge hclk) disable iff (!hresetn)
        (live_q && !hready_out) |=> (hready_out && hresp));

    // R8: OKAY responses never wait
    a_r8_okay_zero_wait: assert property (@(posedge hclk) disable iff (!hresetn)
        !hresp |-> hready_out);

    // R5: a non-access address phase gives a quiet next cycle
    a_r5_idle_quiet: assert property (@(posedge hclk) disable iff (!hresetn)
        (live_q && hready_in && !(hsel && htrans[1]))
            |=> (hready_out && !hresp && hrdata == '0));

    // R9: a write data phase drives no read data
    a_r9_write_no_rdata: assert property (@(posedge hclk) disable iff (!hresetn)
        (live_q && hready_in && hsel && htrans[1] && hwrite) |=> (hrdata == '0));

endmodule

bind regbank_slave regbank_checker #(.DATA_W(DATA_W)) u_chk (
    .hclk       (hclk),
    .hresetn    (hresetn),
    .hsel       (hsel),
    .hwrite     (hwrite),
    .htrans     (htrans),
    .hready_in  (hready_in),
    .hrdata     (hrdata),
    .hready_out (hready_out),
    .hresp      (hresp)
);

// File: tb/regbank_slave_tb.sv
`timescale 1ns/1ps
module regbank_slave_tb;

    logic        hclk = 1'b0;
    logic        hresetn;
    logic        hsel;
    logic [31:0] haddr;
    logic        hwrite;
    logic [1:0]  htrans;
    logic [2:0]  hsize;
    logic [31:0] hwdata;
    logic        hready_in;
    logic [31:0] hrdata;
    logic        hready_out;
    logic        hresp;
    logic        force_stall;

    assign hready_in = hready_out && !force_stall;

    always #4 hclk = ~hclk;

    regbank_slave u_dut (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
        .hwrite(hwrite), .htrans(htrans), .hsize(hsize), .hwdata(hwdata),
        .hready_in(hready_in), .hrdata(hrdata), .hready_out(hready_out),
        .hresp(hresp)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string rd_tag   = "R2";

    logic [31:0] model [8];

    bit          p_valid, p_wr, p_err;
    logic [2:0]  p_idx;
    logic [3:0]  p_lanes;
    logic [31:0] p_wdata;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] lanes_of(logic [2:0] sz, logic [1:0] lo);
        case (sz)
            3'd0:    return 4'b0001 << lo;
            3'd1:    return lo[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic drive_idle();
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hsize = 3'd2;
        haddr = '0; force_stall = 1'b0;
    endtask

    // one bus cycle, entered and left at a falling edge
    task automatic step(bit sel, logic [1:0] tr, bit wr, logic [2:0] sz,
                        logic [31:0] addr, logic [31:0] wd, bit stall);
        if (p_valid && p_err) begin
            check("R7 first cycle ready", 32'(hready_out), 32'd0);
            check("R7 first cycle resp", 32'(hresp), 32'd1);
            drive_idle();
            @(negedge hclk);
            check("R7 second cycle ready", 32'(hready_out), 32'd1);
            check("R7 second cycle resp", 32'(hresp), 32'd1);
        end else if (p_valid && p_wr) begin
            hwdata = p_wdata;
            check("R8 write ready", 32'(hready_out), 32'd1);
            check("R8 write resp", 32'(hresp), 32'd0);
            check("R9 write rdata", hrdata, 32'd0);
            for (int k = 0; k < 4; k++)
                if (p_lanes[k]) model[p_idx][8*k +: 8] = p_wdata[8*k +: 8];
        end else if (p_valid) begin
            check(rd_tag, hrdata, model[p_idx]);
            check("R8 read ready", 32'(hready_out), 32'd1);
            check("R8 read resp", 32'(hresp), 32'd0);
        end else begin
            check("R9 idle rdata", hrdata, 32'd0);
            check("R8 idle ready", 32'(hready_out), 32'd1);
            check("R8 idle resp", 32'(hresp), 32'd0);
        end
        hsel = sel; htrans = tr; hwrite = wr; hsize = sz; haddr = addr;
        force_stall = stall;
        p_valid = sel && tr[1] && !stall;
        p_wr    = wr;
        p_err   = (sz > 3'd2);
        p_idx   = addr[4:2];
        p_lanes = lanes_of(sz, addr[1:0]);
        p_wdata = wd;
        @(negedge hclk);
    endtask

    task automatic do_write(logic [2:0] idx, logic [1:0] lo, logic [2:0] sz, logic [31:0] d);
        step(1, 2'b10, 1, sz, {27'h0, idx, lo}, d, 0);
    endtask

    task automatic do_read(logic [2:0] idx);
        step(1, 2'b11, 0, 3'd2, {27'h0, idx, 2'b00}, 32'h0, 0);
    endtask

    task automatic idle();
        step(0, 2'b00, 0, 3'd2, 32'h0, 32'h0, 0);
    endtask

    task automatic read_all(string tag);
        rd_tag = tag;
        for (int r = 0; r < 8; r++) do_read(3'(r));
        idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_2024);
        for (int r = 0; r < 8; r++) model[r] = '0;
        p_valid = 0; p_wr = 0; p_err = 0; p_idx = '0; p_lanes = '0; p_wdata = '0;
        hwdata = '0;
        drive_idle();
        hresetn = 1'b0;
        repeat (3) @(negedge hclk);
        check("R1 reset ready", 32'(hready_out), 32'd1);
        check("R1 reset resp", 32'(hresp), 32'd0);
        check("R1 reset rdata", hrdata, 32'd0);
        hresetn = 1'b1;
        @(negedge hclk);
        read_all("R1 reset register value");

        // R2: full-word writes, then readback
        for (int r = 0; r < 8; r++) do_write(3'(r), 2'b00, 3'd2, 32'hA5000000 | (32'(r) * 32'h01010101));
        read_all("R2 word readback");

        // R6: write then read of the same register back to back
        do_write(3'd3, 2'b00, 3'd2, 32'hDEADBEEF);
        rd_tag = "R6 pipelined read after write";
        do_read(3'd3);
        do_write(3'd6, 2'b00, 3'd2, 32'h12345678);
        do_read(3'd6);
        idle();

        // R3: byte lanes, with all other bytes of hwdata set
        for (int k = 0; k < 4; k++) begin
            do_write(3'd5, 2'(k), 3'd0, 32'hFFFFFFFF ^ (32'h11 << (8 * k)));
            rd_tag = "R3 byte lane write";
            do_read(3'd5);
        end
        idle();

        // R4: halfword lanes chosen by the address bit 1, bit 0 ignored
        do_write(3'd2, 2'b01, 3'd1, 32'hCAFE1357);
        rd_tag = "R4 low halfword";
        do_read(3'd2);
        do_write(3'd2, 2'b11, 3'd1, 32'hBEEF2468);
        rd_tag = "R4 high halfword";
        do_read(3'd2);
        idle();

        // R5: idle, busy, deselected and stalled phases are not captured
        step(1, 2'b00, 1, 3'd2, 32'h0, 32'h11111111, 0);
        step(1, 2'b01, 1, 3'd2, 32'h0, 32'h22222222, 0);
        step(0, 2'b10, 1, 3'd2, 32'h0, 32'h33333333, 0);
        step(1, 2'b10, 1, 3'd2, 32'h0, 32'h44444444, 1);
        hwdata = 32'h44444444;
        idle();
        rd_tag = "R5 ignored phase left register";
        do_read(3'd0);
        idle();

        // R7: oversize write is refused, register unchanged
        step(1, 2'b10, 1, 3'd3, 32'h4, 32'h99999999, 0);
        rd_tag = "R7 register after error";
        do_read(3'd1);
        step(1, 2'b10, 0, 3'd7, 32'h8, 32'h0, 0);
        do_read(3'd1);
        idle();

        // random mixed traffic
        rd_tag = "R2 random read";
        for (int i = 0; i < 3000; i++) begin
            bit          s;
            logic [1:0]  t;
            logic [2:0]  z;
            s = ($urandom_range(0, 9) != 0);
            t = 2'($urandom_range(0, 3));
            z = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(3, 7)) : 3'($urandom_range(0, 2));
            step(s, t, 1'($urandom_range(0, 1)), z, $urandom(), $urandom(), 0);
        end
        idle();
        read_all("R2 final readback");
        finish_run();
    end

endmodule